// File: doc/BRIEF.md
# Clock Monitor Error Detector

This block watches the system clock and flags when it runs below a minimum rate. It measures the system clock against a slow reference signal from an independent source. That reference is synchronised into the system-clock domain. On every rising edge of the reference, the block takes the number of system-clock cycles counted since the previous rising edge. It compares that count with a parameterised minimum. A count of zero is always treated as a fault. The error output `clk_err_n` is active-low and registered.

The monitor comes out of reset armed, and it starts in the fault condition. While reset is asserted the error output is held high. As soon as reset ends, the output is driven low, and it stays low until the clock has been shown to be fast enough. The error is not cleared by a good measurement alone. After a good measurement the block waits for two rising edges of a timer prescaler tap, `t0_tap`. That tap is not aligned with the moment the clock became good, so the release comes 16 to 32 timer cycles later. Any bad measurement during that wait, or after the release, puts the block back into the fault condition.

Software can disarm the monitor by writing its enable bit low. A disarmed monitor holds the error output high. When the monitor is re-armed, it starts again from the fault condition. The block also presents the companion watchdog service-window bits, which reset sets to all ones to select the widest window.

Top module: `clkmon_top`

## Requirements
- R1: While `rst` is high, from the first clock edge onward, `clk_err_n` is 1, `mon_en` is 1 and every bit of `wd_window` is 1.
- R2: In the cycle after `rst` is released with `mon_en` = 1, `clk_err_n` goes to 0. It stays 0 while no good measurement has been followed by qualification.
- R3: A good measurement alone does not release the error. After a good measurement, `clk_err_n` stays 0 until two rising edges of `t0_tap` have been seen, and it is still 0 after only one.
- R4: After the second rising edge of `t0_tap` that follows a good measurement, with no bad measurement in between, `clk_err_n` goes to 1 within three clock cycles.
- R5: A bad measurement while the error is released drives `clk_err_n` to 0 in the clock cycle after the measurement is taken.
- R6: A bad measurement during qualification discards any `t0_tap` edges already counted. After the next good measurement, two fresh edges are required.
- R7: A write with `en_we` = 1 and `en_wdata` = 0 clears `mon_en`, and the disarmed monitor holds `clk_err_n` at 1 whatever the reference shows. A write with `en_wdata` = 1 re-arms the monitor in the fault condition, so `clk_err_n` is 0.
- R8: A measurement counts the system-clock cycles between successive synchronised rising edges of `ref_in`. The first rising edge after reset is not a measurement. A count of at least `MIN_COUNT` (default 16) is good, and a count of `MIN_COUNT`-1 is bad.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock under test |
| rst | input | 1 | Synchronous active-high reset |
| ref_in | input | 1 | Slow reference signal, asynchronous; one period per measurement |
| t0_tap | input | 1 | Timer prescaler tap in the clk domain; its rising edges qualify release |
| en_we | input | 1 | Write strobe for the monitor enable bit |
| en_wdata | input | 1 | Value written to the enable bit |
| clk_err_n | output | 1 | Active-low clock error, registered |
| mon_en | output | 1 | Current monitor enable bit, 1 after reset |
| wd_window | output | WD_W | Watchdog service-window bits, all ones after reset |

## Verification
The assertions assume that `ref_in` stays at each level for at least as many clock cycles as the synchroniser has stages, so that every rising edge reaches the meter. They also assume that `t0_tap` is already synchronous to `clk`. The bench drives `ref_in` with periods of 8 cycles or more, each half at least 4 cycles. It pulses `t0_tap` for 3 cycles high and 3 low, and changes both only on falling clock edges. The bench holds `ref_in` idle while it pulses `t0_tap`, so no measurement falls into the qualification wait except where a vector asks for one.

// File: rtl/clkmon_pkg.sv
package clkmon_pkg;
  typedef enum logic [1:0] {
    MON_FAULT = 2'd0,
    MON_QUAL  = 2'd1,
    MON_OK    = 2'd2
  } mon_state_e;
endpackage

// File: rtl/clkmon_meter.sv
// Counts clk cycles per reference period and grades each period.
module clkmon_meter #(
  parameter int CNT_W       = 8,
  parameter int MIN_COUNT   = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ref_async,
  output logic meas_valid,
  output logic meas_good
);
  localparam logic [CNT_W-1:0] MIN_V = CNT_W'(MIN_COUNT);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   ref_prev;
  logic                   primed;
  logic [CNT_W-1:0]       cnt;
  logic                   ref_rise;

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) sync_q[0] <= 1'b0;
          else     sync_q[0] <= ref_async;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) sync_q[g] <= 1'b0;
          else     sync_q[g] <= sync_q[g-1];
        end
      end
    end
  endgenerate

  assign ref_rise = sync_q[SYNC_STAGES-1] & ~ref_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_prev   <= 1'b0;
      primed     <= 1'b0;
      cnt        <= '0;
      meas_valid <= 1'b0;
      meas_good  <= 1'b0;
    end else begin
      ref_prev   <= sync_q[SYNC_STAGES-1];
      meas_valid <= 1'b0;
      if (ref_rise) begin
        primed     <= 1'b1;
        meas_valid <= primed;
        meas_good  <= (cnt != '0) && (cnt >= MIN_V);
        cnt        <= CNT_W'(1);
      end else if (cnt != '1) begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/clkmon_qual.sv
// Counts rising edges of the timer tap while qualification is active.
module clkmon_qual #(
  parameter int QUAL_EDGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic t0_bit,
  input  logic active,
  output logic done
);
  localparam int QW = $clog2(QUAL_EDGES + 1);
  localparam logic [QW-1:0] LAST = QW'(QUAL_EDGES);

  logic          t0_prev;
  logic [QW-1:0] edge_cnt;
  logic          t0_rise;

  assign t0_rise = t0_bit & ~t0_prev;
  assign done    = (edge_cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      t0_prev  <= 1'b0;
      edge_cnt <= '0;
    end else begin
      t0_prev <= t0_bit;
      if (!active)                      edge_cnt <= '0;
      else if (t0_rise && !done)        edge_cnt <= edge_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/clkmon_top.sv
module clkmon_top #(
  parameter int CNT_W       = 8,
  parameter int MIN_COUNT   = 16,
  parameter int SYNC_STAGES = 2,
  parameter int QUAL_EDGES  = 2,
  parameter int WD_W        = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ref_in,
  input  logic            t0_tap,
  input  logic            en_we,
  input  logic            en_wdata,
  output logic            clk_err_n,
  output logic            mon_en,
  output logic [WD_W-1:0] wd_window
);
  import clkmon_pkg::*;

  mon_state_e state, st_nxt;
  logic       en_nxt;
  logic       meas_valid, meas_good, qual_done;

  clkmon_meter #(
    .CNT_W(CNT_W), .MIN_COUNT(MIN_COUNT), .SYNC_STAGES(SYNC_STAGES)
  ) u_meter (
    .clk(clk), .rst(rst), .ref_async(ref_in),
    .meas_valid(meas_valid), .meas_good(meas_good)
  );

  clkmon_qual #(.QUAL_EDGES(QUAL_EDGES)) u_qual (
    .clk(clk), .rst(rst), .t0_bit(t0_tap),
    .active(state == MON_QUAL), .done(qual_done)
  );

  always_comb begin
    en_nxt = en_we ? en_wdata : mon_en;
    st_nxt = state;
    case (state)
      MON_FAULT: if (meas_valid && meas_good) st_nxt = MON_QUAL;
      MON_QUAL: begin
        if (meas_valid && !meas_good) st_nxt = MON_FAULT;
        else if (qual_done)           st_nxt = MON_OK;
      end
      MON_OK:    if (meas_valid && !meas_good) st_nxt = MON_FAULT;
      default:   st_nxt = MON_FAULT;
    endcase
    if (!en_nxt) st_nxt = MON_FAULT;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= MON_FAULT;
      mon_en    <= 1'b1;
      clk_err_n <= 1'b1;
      wd_window <= '1;
    end else begin
      state     <= st_nxt;
      mon_en    <= en_nxt;
      clk_err_n <= !(en_nxt && (st_nxt != MON_OK));
    end
  end
endmodule

// File: rtl/clkmon_checker.sv
module clkmon_checker #(
  parameter int WD_W = 2
) (
  input logic            clk,
  input logic            rst,
  input logic            en_we,
  input logic            clk_err_n,
  input logic            mon_en,
  input logic [WD_W-1:0] wd_window,
  input logic            meas_valid,
  input logic            meas_good,
  input logic            qual_done
);
  AST_RESET_INHIBIT: assert property (@(posedge clk)
    rst |=> (clk_err_n && mon_en && (&wd_window))); // R1

  AST_DISARM_HIGH: assert property (@(posedge clk) disable iff (rst)
    !mon_en |-> clk_err_n); // R7

  AST_RELEASE_QUALIFIED: assert property (@(posedge clk) disable iff (rst)
    ($rose(clk_err_n) && mon_en) |-> $past(qual_done)); // R4

  AST_BAD_MEAS_FAULT: assert property (@(posedge clk) disable iff (rst)
    (meas_valid && !meas_good && mon_en && !en_we) |=> !clk_err_n); // R5
endmodule

bind clkmon_top clkmon_checker #(.WD_W(WD_W)) u_chk (
  .clk(clk), .rst(rst), .en_we(en_we), .clk_err_n(clk_err_n),
  .mon_en(mon_en), .wd_window(wd_window), .meas_valid(meas_valid),
  .meas_good(meas_good), .qual_done(qual_done)
);

// File: tb/clkmon_top_tb.sv
module clkmon_top_tb;
  localparam int NV = 8;
  // period in clk cycles, t0_tap pulses, expected clk_err_n, requirement
  localparam int    VP [NV] = '{20, 20, 20, 15, 16, 10, 16, 16};
  localparam int    VT [NV] = '{ 0,  1,  1,  0,  1,  0,  1,  1};
  localparam int    VE [NV] = '{ 0,  0,  1,  0,  0,  0,  0,  1};
  localparam string VR [NV] = '{"R3", "R3", "R4", "R8", "R8", "R6", "R6", "R4"};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ref_in = 1'b0, t0_tap = 1'b0, en_we = 1'b0, en_wdata = 1'b0;
  logic clk_err_n, mon_en;
  logic [1:0] wd_window;
  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  clkmon_top u_dut (
    .clk(clk), .rst(rst), .ref_in(ref_in), .t0_tap(t0_tap),
    .en_we(en_we), .en_wdata(en_wdata), .clk_err_n(clk_err_n),
    .mon_en(mon_en), .wd_window(wd_window)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ref_periods(input int n, input int p);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); ref_in = 1'b1;
      wait_cyc(p / 2);
      ref_in = 1'b0;
      wait_cyc(p - p / 2 - 1);
    end
    wait_cyc(6);
  endtask

  task automatic t0_pulse();
    @(negedge clk); t0_tap = 1'b1;
    wait_cyc(3); t0_tap = 1'b0;
    wait_cyc(3);
  endtask

  task automatic write_en(input logic v);
    @(negedge clk); en_we = 1'b1; en_wdata = v;
    @(negedge clk); en_we = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    wait_cyc(4);
    chk("R1 err_n in reset", int'(clk_err_n), 1);
    chk("R1 mon_en in reset", int'(mon_en), 1);
    chk("R1 wd_window in reset", int'(wd_window), 3);
    rst = 1'b0;
    wait_cyc(3);
    chk("R2 err_n after reset", int'(clk_err_n), 0);

    for (int v = 0; v < NV; v++) begin
      ref_periods(3, VP[v]);
      for (int k = 0; k < VT[v]; k++) t0_pulse();
      wait_cyc(4);
      chk(VR[v], int'(clk_err_n), VE[v]);
    end

    write_en(1'b0);
    wait_cyc(2);
    chk("R7 mon_en cleared", int'(mon_en), 0);
    ref_periods(3, 8);
    chk("R7 err_n high when disarmed", int'(clk_err_n), 1);
    write_en(1'b1);
    wait_cyc(2);
    chk("R7 err_n after rearm", int'(clk_err_n), 0);
    write_en(1'b0);
    wait_cyc(2);
    @(negedge clk); rst = 1'b1;
    wait_cyc(2);
    chk("R1 mon_en restored", int'(mon_en), 1);
    chk("R1 err_n in second reset", int'(clk_err_n), 1);
    chk("R1 wd_window", int'(wd_window), 3);
    rst = 1'b0;
    wait_cyc(3);
    chk("R2 err_n after second reset", int'(clk_err_n), 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule